// File: doc/BRIEF.md
# Time-Multiplexed Pixel Bus Formatter

This block takes a stream of processed pixels and drives them onto a narrow panel data bus. The bus can be 8, 9, 12 or 16 bits wide. When time-division multiplexing is off, each accepted pixel produces one bus word. That word holds the most significant bits of the pixel that fit on the bus.

When multiplexing is on, a pixel is spread over one, two or three bus cycles. Each of the three cycle slots has two programmable bit counts. The first count says how many bits of the current pixel go out in that slot. The second says how many bits of a following pixel go out there. Setting both counts allows two pixels to share three bus cycles.

Pixels arrive with valid/ready handshaking. The bus side is a registered data word with a data-enable strobe. Configuration is assumed static while a group of bus cycles is in progress.

Top module: `tdm_pixel_formatter`

## Requirements
- R1: After a synchronous active-low reset, `bus_de` and `bus_data` are zero and `cfg_err` is clear. With `in_valid` low, `in_ready` is low.
- R2: With `tdm_en` low, every cycle with `in_valid` high is accepted with `in_ready` high. That pixel produces one bus word, which carries its upper W bits, where W is the selected bus width.
- R3: `width_sel` selects the bus width W: code 0 is 8 bits, 1 is 9, 2 is 12 and 3 is 16. The word occupies `bus_data[W-1:0]`, and bits at W and above are zero.
- R4: With `tdm_en` high, `cyc_fmt` code 0 gives one bus cycle per group, code 1 gives two and code 2 gives three.
- R5: In slot k, the first-pixel count is `p1_cnt[5k+4:5k]`. That many bits are taken MSB-first from the first pixel, continuing where slot k-1 stopped. They are placed from bit W-1 downward. Bits past the pixel's end read as zero, and unused low bits are zero.
- R6: Packing is active when `tdm_en` is high, the group has more than one cycle, and some second-pixel count `p2_cnt[5k+4:5k]` with k from 1 to the last slot is nonzero. The second pixel is the input presented in slots 1 and later. Its bits are taken MSB-first, continuing from slot to slot, and placed directly below that slot's first-pixel bits. The slot-0 second-pixel count is ignored.
- R7: Without packing, `in_ready` rises only in the last slot of a group. With packing, it rises in slot 0 and in the last slot.
- R8: A cycle with `in_valid` low does not advance the slot, raises no `in_ready` and produces no `bus_de`.
- R9: When a slot's two counts sum to more than W, the bits beyond W are dropped and `cfg_err` is set. `cfg_err` then stays high until reset.
- R10: The bus word and `bus_de` appear one clock after the accepting cycle. `bus_data` is zero whenever `bus_de` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdm_en | input | 1 | Enables multi-cycle formatting |
| cyc_fmt | input | 2 | Bus cycles per group code |
| width_sel | input | 2 | Bus width code |
| p1_cnt | input | 15 | Per-slot first-pixel bit counts, 5 bits per slot |
| p2_cnt | input | 15 | Per-slot second-pixel bit counts, 5 bits per slot |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel consumed this cycle |
| in_data | input | 24 | Pixel value |
| bus_data | output | 16 | Panel bus word, left-aligned to width |
| bus_de | output | 1 | Bus word valid |
| cfg_err | output | 1 | Sticky bit-count overflow flag |

## Verification
A slot counter that is off by one shows up in two ways within one group. The handshake completes in the wrong slot, and the next word carries bits from the wrong offset. A bad running offset corrupts the second bus word of a group on the clock after its slot. A wrong choice of source for the second pixel changes the middle and last words of a packed group. An overflow flag that clears itself is visible as soon as a later, clean group runs.

// File: rtl/tdm_fmt_pkg.sv
// Package: shared encodings and decode helpers for the pixel bus formatter.
// Assumes bus widths never exceed 16 bits and at most three cycle slots.
package tdm_fmt_pkg;

    typedef enum logic [1:0] {
        BUSW_8  = 2'd0,
        BUSW_9  = 2'd1,
        BUSW_12 = 2'd2,
        BUSW_16 = 2'd3
    } busw_e;

    typedef enum logic [1:0] {
        SLOTS_ONE   = 2'd0,
        SLOTS_TWO   = 2'd1,
        SLOTS_THREE = 2'd2,
        SLOTS_RSVD  = 2'd3
    } slots_e;

    // Decode the width code into a bit count.
    function automatic logic [4:0] bus_width(input logic [1:0] sel);
        logic [4:0] w;
        case (busw_e'(sel))
            BUSW_8:  w = 5'd8;
            BUSW_9:  w = 5'd9;
            BUSW_12: w = 5'd12;
            default: w = 5'd16;
        endcase
        return w;
    endfunction

    // Index of the last slot in a group; a single slot when multiplexing is off.
    function automatic logic [1:0] last_slot(input logic tdm, input logic [1:0] fmt);
        logic [1:0] l;
        if (!tdm) begin
            l = 2'd0;
        end else begin
            case (slots_e'(fmt))
                SLOTS_ONE: l = 2'd0;
                SLOTS_TWO: l = 2'd1;
                default:   l = 2'd2;
            endcase
        end
        return l;
    endfunction

endpackage

// File: rtl/tdm_cycle_seq.sv
// Module: slot sequencer. Tracks the slot within a group, detects packing
// and produces the input handshake. Assumes configuration is static while
// a group is in progress and that every slot consumes one valid cycle.
module tdm_cycle_seq
    import tdm_fmt_pkg::*;
#(
    parameter int NCYC  = 3,
    parameter int CNT_W = 5,
    parameter int CYC_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tdm_en,
    input  logic [1:0]             cyc_fmt,
    input  logic [NCYC*CNT_W-1:0]  p2_cnt,
    input  logic                   in_valid,
    output logic [CYC_W-1:0]       cyc,
    output logic                   seq_last,
    output logic                   pack,
    output logic                   in_ready,
    output logic                   capture
);

    logic [CYC_W-1:0] last_idx;
    logic [CYC_W-1:0] cyc_q;
    logic [NCYC-1:0]  p2_used;

    assign last_idx = CYC_W'(last_slot(tdm_en, cyc_fmt));

    // A slot carries second-pixel bits only when it lies inside the group and is not slot 0.
    for (genvar k = 0; k < NCYC; k++) begin : g_p2_used
        if (k == 0) begin : g_first
            assign p2_used[k] = 1'b0;
        end else begin : g_later
            assign p2_used[k] = (p2_cnt[k*CNT_W +: CNT_W] != '0) && (CYC_W'(k) <= last_idx);
        end
    end

    assign pack     = tdm_en && (|p2_used);
    assign seq_last = (cyc_q >= last_idx);
    assign in_ready = in_valid && (seq_last || (pack && (cyc_q == '0)));
    assign capture  = in_valid && (cyc_q == '0);
    assign cyc      = cyc_q;

    // Advance the slot on every accepted cycle and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (in_valid) begin
            cyc_q <= seq_last ? '0 : cyc_q + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_cnt_select.sv
// Module: per-slot count and offset selection. Builds running bit offsets
// for both pixels from the programmed counts and picks those of the
// current slot. Assumes the slot-0 second-pixel count is never used.
module tdm_cnt_select #(
    parameter int NCYC  = 3,
    parameter int CNT_W = 5,
    parameter int CYC_W = 2,
    parameter int PTR_W = 7
) (
    input  logic [CYC_W-1:0]       cyc,
    input  logic                   tdm_en,
    input  logic                   pack,
    input  logic [4:0]             width,
    input  logic [NCYC*CNT_W-1:0]  p1_cnt,
    input  logic [NCYC*CNT_W-1:0]  p2_cnt,
    output logic [CNT_W-1:0]       n1,
    output logic [CNT_W-1:0]       n2,
    output logic [PTR_W-1:0]       ptr1,
    output logic [PTR_W-1:0]       ptr2
);

    logic [CNT_W-1:0] c1   [NCYC];
    logic [CNT_W-1:0] c2   [NCYC];
    logic [PTR_W-1:0] pre1 [NCYC];
    logic [PTR_W-1:0] pre2 [NCYC];

    // Unpack counts and form prefix sums of the bits already sent.
    for (genvar k = 0; k < NCYC; k++) begin : g_pre
        assign c1[k] = p1_cnt[k*CNT_W +: CNT_W];
        assign c2[k] = p2_cnt[k*CNT_W +: CNT_W];
        if (k == 0) begin : g_zero
            assign pre1[k] = '0;
            assign pre2[k] = '0;
        end else if (k == 1) begin : g_one
            assign pre1[k] = PTR_W'(c1[0]);
            assign pre2[k] = '0;
        end else begin : g_rest
            assign pre1[k] = pre1[k-1] + PTR_W'(c1[k-1]);
            assign pre2[k] = pre2[k-1] + PTR_W'(c2[k-1]);
        end
    end

    // Select the counts and offsets of the active slot.
    always_comb begin
        logic [CNT_W-1:0] s1, s2;
        logic [PTR_W-1:0] o1, o2;
        s1 = '0;
        s2 = '0;
        o1 = '0;
        o2 = '0;
        for (int i = 0; i < NCYC; i++) begin
            if (cyc == CYC_W'(i)) begin
                s1 = c1[i];
                s2 = c2[i];
                o1 = pre1[i];
                o2 = pre2[i];
            end
        end
        n1   = tdm_en ? s1 : CNT_W'(width);
        ptr1 = tdm_en ? o1 : '0;
        n2   = (tdm_en && pack && (cyc != '0)) ? s2 : '0;
        ptr2 = o2;
    end

endmodule

// File: rtl/tdm_bit_slicer.sv
// Module: bit slicer. Cuts a run of bits from each pixel, MSB-first, joins
// them and left-aligns the result on a bus of the selected width. Assumes
// BUS_MAX does not exceed twice the pixel width.
module tdm_bit_slicer #(
    parameter int PIX_W   = 24,
    parameter int BUS_MAX = 16,
    parameter int CNT_W   = 5,
    parameter int PTR_W   = 7
) (
    input  logic [PIX_W-1:0]   pix1,
    input  logic [PIX_W-1:0]   pix2,
    input  logic [CNT_W-1:0]   n1,
    input  logic [CNT_W-1:0]   n2,
    input  logic [PTR_W-1:0]   ptr1,
    input  logic [PTR_W-1:0]   ptr2,
    input  logic [4:0]         width,
    output logic [BUS_MAX-1:0] word,
    output logic               overflow
);

    localparam int CAT_W = 2 * PIX_W;

    logic [PIX_W-1:0]   s1, s2;
    logic [CAT_W-1:0]   cat;
    logic [BUS_MAX-1:0] top;
    logic [5:0]         rsh;

    // Keep only the requested leading bits of each shifted pixel.
    always_comb begin
        s1 = (pix1 << ptr1) & ~({PIX_W{1'b1}} >> n1);
        s2 = (pix2 << ptr2) & ~({PIX_W{1'b1}} >> n2);
    end

    // Join the two runs and move the joined field down to the bus width.
    always_comb begin
        cat  = {s1, {PIX_W{1'b0}}} | ({s2, {PIX_W{1'b0}}} >> n1);
        top  = cat[CAT_W-1 -: BUS_MAX];
        rsh  = 6'(BUS_MAX) - {1'b0, width};
        word = top >> rsh;
    end

    // Flag slots whose counts ask for more bits than the bus carries.
    assign overflow = ((CNT_W+1)'(n1) + (CNT_W+1)'(n2)) > (CNT_W+1)'(width);

endmodule

// File: rtl/tdm_pixel_formatter.sv
// Module: top of the time-multiplexed pixel bus formatter. Holds the first
// pixel of a group, drives the registered bus word and tracks the sticky
// overflow flag. Assumes configuration changes only between groups.
module tdm_pixel_formatter
    import tdm_fmt_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int BUS_MAX = 16,
    parameter int NCYC    = 3,
    parameter int CNT_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tdm_en,
    input  logic [1:0]            cyc_fmt,
    input  logic [1:0]            width_sel,
    input  logic [NCYC*CNT_W-1:0] p1_cnt,
    input  logic [NCYC*CNT_W-1:0] p2_cnt,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PIX_W-1:0]      in_data,
    output logic [BUS_MAX-1:0]    bus_data,
    output logic                  bus_de,
    output logic                  cfg_err
);

    localparam int CYC_W = (NCYC > 1) ? $clog2(NCYC) : 1;
    localparam int PTR_W = CNT_W + CYC_W;

    logic [CYC_W-1:0]   cyc_q;
    logic               seq_last;
    logic               pack;
    logic               capture;
    logic [4:0]         width;
    logic [PIX_W-1:0]   hold_q;
    logic [PIX_W-1:0]   pix1;
    logic [CNT_W-1:0]   n1, n2;
    logic [PTR_W-1:0]   ptr1, ptr2;
    logic [BUS_MAX-1:0] word;
    logic               overflow;

    assign width = bus_width(width_sel);
    assign pix1  = (cyc_q == '0) ? in_data : hold_q;

    tdm_cycle_seq #(
        .NCYC  (NCYC),
        .CNT_W (CNT_W),
        .CYC_W (CYC_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tdm_en   (tdm_en),
        .cyc_fmt  (cyc_fmt),
        .p2_cnt   (p2_cnt),
        .in_valid (in_valid),
        .cyc      (cyc_q),
        .seq_last (seq_last),
        .pack     (pack),
        .in_ready (in_ready),
        .capture  (capture)
    );

    tdm_cnt_select #(
        .NCYC  (NCYC),
        .CNT_W (CNT_W),
        .CYC_W (CYC_W),
        .PTR_W (PTR_W)
    ) u_sel (
        .cyc    (cyc_q),
        .tdm_en (tdm_en),
        .pack   (pack),
        .width  (width),
        .p1_cnt (p1_cnt),
        .p2_cnt (p2_cnt),
        .n1     (n1),
        .n2     (n2),
        .ptr1   (ptr1),
        .ptr2   (ptr2)
    );

    tdm_bit_slicer #(
        .PIX_W   (PIX_W),
        .BUS_MAX (BUS_MAX),
        .CNT_W   (CNT_W),
        .PTR_W   (PTR_W)
    ) u_slice (
        .pix1     (pix1),
        .pix2     (in_data),
        .n1       (n1),
        .n2       (n2),
        .ptr1     (ptr1),
        .ptr2     (ptr2),
        .width    (width),
        .word     (word),
        .overflow (overflow)
    );

    // Keep the first pixel of a group for the slots after slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= in_data;
        end
    end

    // Register the bus word, its strobe and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_de   <= 1'b0;
            bus_data <= '0;
            cfg_err  <= 1'b0;
        end else begin
            bus_de   <= in_valid;
            bus_data <= in_valid ? word : '0;
            cfg_err  <= cfg_err | (in_valid && tdm_en && overflow);
        end
    end

endmodule

// File: rtl/tdm_pixel_formatter_chk.sv
// Module: assertion checker for the formatter, bound into the top module.
// Assumes a synchronous active-low reset and static configuration per group.
module tdm_pixel_formatter_chk #(
    parameter int BUS_MAX = 16,
    parameter int CYC_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tdm_en,
    input logic               in_valid,
    input logic               in_ready,
    input logic [BUS_MAX-1:0] bus_data,
    input logic               bus_de,
    input logic               cfg_err,
    input logic [CYC_W-1:0]   cyc,
    input logic               pack,
    input logic               seq_last
);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_de |-> (bus_data == '0));

    a_r10_de_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> bus_de);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r8_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !in_ready);

    a_r8_stall_no_de: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !bus_de);

    a_r8_stall_holds_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cyc));

    a_r2_conv_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!tdm_en && in_valid) |-> in_ready);

    a_r4_group_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seq_last) |=> (cyc == '0));

    a_r7_mid_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !seq_last && (cyc != '0)) |-> !in_ready);

    a_r7_pack_first_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pack && (cyc == '0)) |-> in_ready);

endmodule

bind tdm_pixel_formatter tdm_pixel_formatter_chk #(
    .BUS_MAX (BUS_MAX),
    .CYC_W   (CYC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tdm_en   (tdm_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bus_data (bus_data),
    .bus_de   (bus_de),
    .cfg_err  (cfg_err),
    .cyc      (cyc_q),
    .pack     (pack),
    .seq_last (seq_last)
);

// File: tb/tb_tdm_pixel_formatter.sv
`timescale 1ns/1ps
// Directed bench for the formatter: one task per scenario, each checking its own results.
module tb_tdm_pixel_formatter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tdm_en;
    logic [1:0]  cyc_fmt;
    logic [1:0]  width_sel;
    logic [14:0] p1_cnt;
    logic [14:0] p2_cnt;
    logic        in_valid;
    logic        in_ready;
    logic [23:0] in_data;
    logic [15:0] bus_data;
    logic        bus_de;
    logic        cfg_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    int cfg_w;
    int cfg_n;
    int c1 [3];
    int c2 [3];

    always #4 clk = ~clk;

    tdm_pixel_formatter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tdm_en    (tdm_en),
        .cyc_fmt   (cyc_fmt),
        .width_sel (width_sel),
        .p1_cnt    (p1_cnt),
        .p2_cnt    (p2_cnt),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .bus_data  (bus_data),
        .bus_de    (bus_de),
        .cfg_err   (cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected bus word, built bit by bit from the requirement text.
    function automatic logic [15:0] exp_word(input logic [23:0] pa, input logic [23:0] pb,
                                             input int n1, input int n2, input int o1,
                                             input int o2, input int w);
        logic [15:0] r = '0;
        for (int i = 0; i < w; i++) begin
            logic b = 1'b0;
            if (i < n1) begin
                if (o1 + i < 24) b = pa[23 - (o1 + i)];
            end else if (i < n1 + n2) begin
                if (o2 + i - n1 < 24) b = pb[23 - (o2 + i - n1)];
            end
            r[w - 1 - i] = b;
        end
        return r;
    endfunction

    task automatic configure(input bit tdm, input int fmt, input int wsel,
                             input int a0, input int a1, input int a2,
                             input int b0, input int b1, input int b2);
        tdm_en    = tdm;
        cyc_fmt   = 2'(fmt);
        width_sel = 2'(wsel);
        c1[0] = a0; c1[1] = a1; c1[2] = a2;
        c2[0] = b0; c2[1] = b1; c2[2] = b2;
        p1_cnt = {5'(a2), 5'(a1), 5'(a0)};
        p2_cnt = {5'(b2), 5'(b1), 5'(b0)};
        case (wsel)
            0: cfg_w = 8;
            1: cfg_w = 9;
            2: cfg_w = 12;
            default: cfg_w = 16;
        endcase
        cfg_n = tdm ? fmt + 1 : 1;
    endtask

    task automatic idle_cycle(input string req);
        in_valid = 1'b0;
        #1;
        check(in_ready == 1'b0, req, "ready while idle", in_ready, 0);
        @(negedge clk);
        check(bus_de == 1'b0, req, "de while idle", bus_de, 0);
        check(bus_data == 16'h0, req, "data while idle", bus_data, 0);
    endtask

    // One group; stall_at >= 0 inserts two idle cycles before that slot.
    task automatic run_group(input logic [23:0] pa, input logic [23:0] pb, input bit pk,
                             input int stall_at, input string req);
        int o1 = 0;
        int o2 = 0;
        for (int k = 0; k < cfg_n; k++) begin
            int n1, n2;
            bit rdy;
            logic [15:0] e;
            if (k == stall_at) begin
                idle_cycle("R8");
                idle_cycle("R8");
            end
            n1  = tdm_en ? c1[k] : cfg_w;
            n2  = (pk && k > 0) ? c2[k] : 0;
            rdy = (k == cfg_n - 1) || (pk && k == 0);
            e   = exp_word(pa, pb, n1, n2, o1, o2, cfg_w);
            in_valid = 1'b1;
            in_data  = (pk && k > 0) ? pb : pa;
            #1;
            check(in_ready == rdy, "R7", {req, " ready"}, in_ready, rdy);
            @(negedge clk);
            check(bus_de == 1'b1, "R10", {req, " de"}, bus_de, 1);
            check(bus_data == e, req, "bus word", bus_data, e);
            o1 += n1;
            o2 += n2;
        end
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(bus_de == 1'b0, "R1", "de after reset", bus_de, 0);
        check(bus_data == 16'h0, "R1", "data after reset", bus_data, 0);
        check(cfg_err == 1'b0, "R1", "err after reset", cfg_err, 0);
        check(in_ready == 1'b0, "R1", "ready after reset", in_ready, 0);
    endtask

    task automatic t_conventional;
        configure(0, 2, 0, 0, 0, 0, 0, 0, 0);
        run_group(24'hA5C33C, 24'h0, 0, -1, "R2");
        run_group(24'h3C5AF0, 24'h0, 0, -1, "R2");
        configure(0, 0, 3, 0, 0, 0, 0, 0, 0);
        run_group(24'hA5C33C, 24'h0, 0, -1, "R3");
        configure(0, 0, 1, 0, 0, 0, 0, 0, 0);
        run_group(24'hA5C33C, 24'h0, 0, -1, "R3");
        configure(0, 0, 2, 0, 0, 0, 0, 0, 0);
        run_group(24'hFFFFFF, 24'h0, 0, -1, "R3");
    endtask

    task automatic t_three_on_eight;
        configure(1, 2, 0, 8, 8, 8, 0, 0, 0);
        run_group(24'h123456, 24'h0, 0, -1, "R4");
        run_group(24'hFEDCBA, 24'h0, 0, -1, "R5");
    endtask

    task automatic t_two_on_twelve;
        configure(1, 1, 2, 12, 12, 0, 0, 0, 0);
        run_group(24'hABCDEF, 24'h0, 0, -1, "R4");
        configure(1, 0, 3, 16, 0, 0, 0, 7, 0);
        run_group(24'h9ABCDE, 24'h0, 0, -1, "R4");
    endtask

    task automatic t_partial_slices;
        configure(1, 2, 1, 7, 9, 8, 0, 0, 0);
        run_group(24'hC3A5F1, 24'h0, 0, -1, "R5");
        configure(1, 2, 2, 10, 10, 10, 0, 0, 0);
        run_group(24'hFFFFFF, 24'h0, 0, -1, "R5");
    endtask

    task automatic t_packing;
        configure(1, 2, 3, 16, 8, 0, 9, 8, 16);
        run_group(24'h123456, 24'h789ABC, 1, -1, "R6");
        configure(1, 2, 2, 12, 12, 0, 0, 0, 12);
        run_group(24'hF0E1D2, 24'hC3B4A5, 1, -1, "R6");
    endtask

    task automatic t_stall;
        configure(1, 2, 0, 8, 8, 8, 0, 0, 0);
        run_group(24'h55AA33, 24'h0, 0, 1, "R8");
        configure(1, 2, 3, 16, 8, 0, 0, 8, 16);
        run_group(24'h13579B, 24'h2468AC, 1, 2, "R8");
    endtask

    task automatic t_overflow;
        check(cfg_err == 1'b0, "R9", "err before overflow", cfg_err, 0);
        configure(1, 1, 0, 8, 6, 0, 0, 4, 0);
        run_group(24'hB7E15A, 24'h6D2C91, 1, -1, "R9");
        check(cfg_err == 1'b1, "R9", "err after overflow", cfg_err, 1);
        configure(1, 2, 0, 8, 8, 8, 0, 0, 0);
        run_group(24'h010203, 24'h0, 0, -1, "R9");
        check(cfg_err == 1'b1, "R9", "err stays set", cfg_err, 1);
        t_reset();
        check(cfg_err == 1'b0, "R9", "err cleared by reset", cfg_err, 0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        configure(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        t_reset();
        t_conventional();
        t_three_on_eight();
        t_two_on_twelve();
        t_partial_slices();
        t_packing();
        t_stall();
        t_overflow();
        done = 1;
        finish_run();
    end

endmodule